// File: doc/BRIEF.md
# Random Multi-Channel Hit Pattern Generator

This block turns a stream of random 8-bit codes into channel hit patterns for exercising multi-channel trigger electronics. Each accepted code produces one registered pattern on a 256-bit channel vector, together with a one-cycle valid strobe. The system expects one code per 25 ns bunch period, which is a 40 MHz event rate.

A two-bit mode register picks how each code becomes a pattern. Broadcast mode drives every channel. Single-channel mode drives only the channel whose index equals the code. Cluster mode drives three neighbouring channels centred on the code, and the cluster is held inside the channel range at both ends. A host writes the mode, and the new mode takes effect from the next accepted code onward. Each pattern is built from one mode only.

Top module: `hitgen_top`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears `hit_vec` and `hit_vld` to zero and selects single-channel mode (01).
- R2: `hit_vld` is high in the cycle after a clock edge where `code_vld` was high, and low otherwise. `hit_vec` is all zeros whenever `hit_vld` is low.
- R3: In broadcast mode (mode value 00), an accepted code produces a pattern with all 256 bits of `hit_vec` set.
- R4: In single-channel mode (mode value 01), an accepted code c produces a pattern with only bit c of `hit_vec` set.
- R5: In cluster mode (mode value 10), an accepted code c with 1 <= c <= 254 produces a pattern with exactly bits c-1, c and c+1 set.
- R6: In cluster mode, code 0 sets bits 0, 1 and 2, and code 255 sets bits 253, 254 and 255.
- R7: Mode value 11 is reserved. An accepted code then produces an all-zero `hit_vec`, and `hit_vld` still pulses.
- R8: A write (`cfg_we` high at an edge) stores `cfg_mode`. A code accepted at that same edge is decoded with the previous mode, and codes accepted at later edges use the new mode.
- R9: When `cfg_we` is low, `cfg_mode` has no effect and the stored mode is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Mode write enable |
| cfg_mode | input | 2 | Mode value to store: 00 broadcast, 01 single, 10 cluster, 11 reserved |
| code_vld | input | 1 | Random code is present this cycle |
| code | input | 8 | Random channel code |
| hit_vec | output | 256 | Registered channel pattern, one bit per channel |
| hit_vld | output | 1 | Pattern valid strobe, one cycle per accepted code |

## Verification
The bench builds the block with its default code width of 8 bits, which gives 256 channels. At this size every code value, including both cluster clamp edges at 0 and 255, is reachable both by directed cases and by the random stream. Random mode writes are mixed with codes, sometimes at the same edge, so the previous-mode rule of R8 is exercised repeatedly across every pair of modes. The reserved mode and writes with the enable low are also covered.

// File: rtl/hitgen_pkg.sv
package hitgen_pkg;

    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        MODE_ALL   = 2'b00,
        MODE_PAD   = 2'b01,
        MODE_STRIP = 2'b10,
        MODE_RSV   = 2'b11
    } hit_mode_e;

    localparam hit_mode_e MODE_RESET = MODE_PAD;

endpackage

// File: rtl/hitgen_cfg.sv
module hitgen_cfg
    import hitgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [MODE_W-1:0] wdata,
    output hit_mode_e         mode
);

    always_ff @(posedge clk) begin
        if (rst)
            mode <= MODE_RESET;
        else if (we)
            mode <= hit_mode_e'(wdata);
    end

    // R9: without a write strobe the stored mode does not move
    a_r9_mode_hold: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(mode));

    // R8: a write lands on the next cycle
    a_r8_mode_write: assert property (@(posedge clk) disable iff (rst)
        we |=> (mode == hit_mode_e'($past(wdata))));

endmodule

// File: rtl/hitgen_decode.sv
module hitgen_decode
    import hitgen_pkg::*;
#(
    parameter int CODE_W = 8,
    localparam int NCH = 1 << CODE_W
) (
    input  hit_mode_e         mode,
    input  logic [CODE_W-1:0] code,
    output logic [NCH-1:0]    pattern
);

    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

    logic [CODE_W-1:0] ctr;
    logic [CODE_W:0]   ctr_x;

    // Cluster centre is held one channel inside each end of the range.
    always_comb begin
        if (code == '0)
            ctr = CODE_W'(1);
        else if (code == CODE_MAX)
            ctr = CODE_MAX - CODE_W'(1);
        else
            ctr = code;
        ctr_x = {1'b0, ctr};
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        localparam logic [CODE_W:0] IDX = (CODE_W+1)'(i);
        logic is_pad;
        logic is_near;
        assign is_pad  = ({1'b0, code} == IDX);
        assign is_near = (IDX + (CODE_W+1)'(1) == ctr_x) ||
                         (IDX == ctr_x) ||
                         (IDX == ctr_x + (CODE_W+1)'(1));
        always_comb begin
            unique case (mode)
                MODE_ALL:   pattern[i] = 1'b1;
                MODE_PAD:   pattern[i] = is_pad;
                MODE_STRIP: pattern[i] = is_near;
                default:    pattern[i] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/hitgen_top.sv
module hitgen_top
    import hitgen_pkg::*;
#(
    parameter int CODE_W = 8,
    localparam int NCH = 1 << CODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [MODE_W-1:0] cfg_mode,
    input  logic              code_vld,
    input  logic [CODE_W-1:0] code,
    output logic [NCH-1:0]    hit_vec,
    output logic              hit_vld
);

    hit_mode_e      mode_now;
    logic [NCH-1:0] pattern;

    hitgen_cfg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_mode),
        .mode  (mode_now)
    );

    hitgen_decode #(.CODE_W(CODE_W)) u_dec (
        .mode    (mode_now),
        .code    (code),
        .pattern (pattern)
    );

    // Pattern and strobe are registered once; the vector is a one-cycle pulse.
    always_ff @(posedge clk) begin
        if (rst) begin
            hit_vec <= '0;
            hit_vld <= 1'b0;
        end else begin
            hit_vld <= code_vld;
            hit_vec <= code_vld ? pattern : '0;
        end
    end

    // R1: reset clears outputs and restores the default mode
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!hit_vld && hit_vec == '0 && mode_now == MODE_PAD));

    // R2: strobe follows acceptance by exactly one cycle
    a_r2_vld_follows: assert property (@(posedge clk) disable iff (rst)
        code_vld |=> hit_vld);
    a_r2_vld_quiet: assert property (@(posedge clk) disable iff (rst)
        !code_vld |=> !hit_vld);
    a_r2_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !hit_vld |-> (hit_vec == '0));

    // R3: broadcast fills every channel
    a_r3_all_set: assert property (@(posedge clk) disable iff (rst)
        (code_vld && mode_now == MODE_ALL) |=> (&hit_vec));

    // R4: single-channel output is one-hot
    a_r4_pad_onehot: assert property (@(posedge clk) disable iff (rst)
        (code_vld && mode_now == MODE_PAD) |=> ($countones(hit_vec) == 1));

    // R5/R6: cluster always has three channels
    a_r5_strip_three: assert property (@(posedge clk) disable iff (rst)
        (code_vld && mode_now == MODE_STRIP) |=> ($countones(hit_vec) == 3));

    // R7: reserved mode gives an empty pattern
    a_r7_rsv_empty: assert property (@(posedge clk) disable iff (rst)
        (code_vld && mode_now == MODE_RSV) |=> (hit_vld && hit_vec == '0));

endmodule

// File: tb/hitgen_top_tb_top.sv
module hitgen_top_tb_top;

    localparam int CW  = 8;
    localparam int NCH = 1 << CW;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           cfg_we = 1'b0;
    logic [1:0]     cfg_mode = 2'b00;
    logic           code_vld = 1'b0;
    logic [CW-1:0]  code = '0;
    logic [NCH-1:0] hit_vec;
    logic           hit_vld;

    int total = 0;
    int bad = 0;
    logic [1:0] cur_mode = 2'b01;

    always #4 clk = ~clk;

    hitgen_top #(.CODE_W(CW)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_mode (cfg_mode),
        .code_vld (code_vld),
        .code     (code),
        .hit_vec  (hit_vec),
        .hit_vld  (hit_vld)
    );

    function automatic logic [NCH-1:0] exp_pat(input logic [1:0] m, input int c);
        logic [NCH-1:0] v;
        int ctr;
        v = '0;
        case (m)
            2'b00: v = '1;
            2'b01: v[c] = 1'b1;
            2'b10: begin
                ctr = (c == 0) ? 1 : ((c == NCH-1) ? NCH-2 : c);
                v[ctr-1] = 1'b1;
                v[ctr]   = 1'b1;
                v[ctr+1] = 1'b1;
            end
            default: v = '0;
        endcase
        return v;
    endfunction

    task automatic check(input string tag, input logic [NCH-1:0] ev, input logic evld);
        total++;
        if (hit_vec !== ev || hit_vld !== evld) begin
            bad++;
            $display("FAIL %s: vec=%h vld=%b expected vec=%h vld=%b",
                     tag, hit_vec, hit_vld, ev, evld);
        end
    endtask

    // Called at a falling edge; drives, passes one rising edge, checks at the next falling edge.
    task automatic step(input string tag, input logic we, input logic [1:0] m,
                        input logic v, input int c);
        logic [NCH-1:0] ev;
        cfg_we = we; cfg_mode = m; code_vld = v; code = CW'(c);
        ev = v ? exp_pat(cur_mode, c) : '0;
        @(negedge clk);
        if (we) cur_mode = m;
        check(tag, ev, v);
        cfg_we = 1'b0; code_vld = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        bad++; total++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        check("R1 reset outputs", '0, 1'b0);
        rst = 1'b0;
        step("R1 default mode single", 1'b0, 2'b00, 1'b1, 77);
        step("R2 idle after pulse", 1'b0, 2'b00, 1'b0, 0);
        step("R4 single code 0", 1'b0, 2'b00, 1'b1, 0);
        step("R4 single code 255", 1'b0, 2'b00, 1'b1, 255);
        step("R3 write broadcast", 1'b1, 2'b00, 1'b0, 0);
        step("R3 broadcast", 1'b0, 2'b00, 1'b1, 9);
        step("R8 write cluster", 1'b1, 2'b10, 1'b0, 0);
        step("R6 cluster code 0", 1'b0, 2'b00, 1'b1, 0);
        step("R6 cluster code 255", 1'b0, 2'b00, 1'b1, 255);
        step("R5 cluster code 1", 1'b0, 2'b00, 1'b1, 1);
        step("R5 cluster code 254", 1'b0, 2'b00, 1'b1, 254);
        step("R5 cluster code 128", 1'b0, 2'b00, 1'b1, 128);
        step("R9 ignored mode value", 1'b0, 2'b11, 1'b0, 0);
        step("R9 mode kept", 1'b0, 2'b01, 1'b1, 40);
        step("R8 same-edge write uses old", 1'b1, 2'b11, 1'b1, 7);
        step("R7 reserved empty", 1'b0, 2'b00, 1'b1, 7);
        step("R8 same-edge write back", 1'b1, 2'b01, 1'b1, 3);
        step("R8 new mode applies", 1'b0, 2'b00, 1'b1, 3);
        for (int i = 0; i < 600; i++) begin
            logic we;
            logic v;
            we = ($urandom % 4) == 0;
            v  = ($urandom % 3) != 0;
            step(v ? "R2 R8 random event" : "R2 random idle",
                 we, 2'($urandom), v, int'($urandom % NCH));
        end
        rst = 1'b1;
        step("R1 reset mid-run", 1'b0, 2'b00, 1'b0, 0);
        cur_mode = 2'b01;
        rst = 1'b0;
        step("R1 mode back to single", 1'b0, 2'b00, 1'b1, 200);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule